// File: doc/BRIEF.md
# Selectable Reference Frequency Divider

This block turns a reference clock into the comparison rate for a phase-locked synthesiser loop. It divides in two stages. A fixed stage divides by 100. A second stage divides that result again by a ratio taken from a 3-bit select code. The comparison output is a pulse one reference clock wide, produced once for each full divide cycle. A monitor output is a square wave at one hundredth of the reference rate, and it is meant for trimming the crystal.

The select code is held in two registers. A pending register captures the code on a load strobe. The divider does not use that code at once: it is copied into the active register at the next terminal count of the whole divider. Because of this, a period that is already running always completes with the ratio it started with. The select input alone, without the strobe, changes nothing.

Top module: `ref_divider`

## Requirements
- R1: The active select code sets the total division ratio, from reference clocks to comparison pulses: 3'b111→100, 3'b011→200, 3'b110→500, 3'b010→400, 3'b001→800, 3'b101→1000, 3'b000→1600, 3'b100→2000. Every pulse falls on a boundary of the divide-by-100 stage.
- R2: `cmp_pulse` is high for exactly one reference clock per divide cycle.
- R3: `mon_out` toggles every 50 reference clocks, which gives a 50% duty cycle at 1/100 of the reference rate. It does not depend on the select code.
- R4: A change on `sel_in` while `load` is low has no effect on the ratio.
- R5: A code captured by `load` takes effect only at the next terminal count. The period in progress, and a period that starts on the same edge as a late load, keep the old ratio.
- R6: A `load` sampled on the same edge as the terminal count applies its code to the period that starts on that edge.
- R7: The synchronous reset `rst` clears both stages, drives `cmp_pulse` and `mon_out` low and selects code 3'b000. The first pulse after reset release comes 1600 clocks later, and the first rise of `mon_out` comes 50 clocks later.
- R8: If `load` pulses more than once within a period, the last captured code is the one applied at the terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_in | input | 3 | Ratio select code |
| load | input | 1 | Strobe that captures `sel_in` into the pending register |
| cmp_pulse | output | 1 | One-clock pulse at the comparison rate |
| mon_out | output | 1 | Square wave at 1/100 of the reference rate |

## Verification
Two events can fall on the same clock edge. One is the capture of a new code by `load`. The other is the terminal count that moves the pending code into the active register. The bench times a strobe so that it is sampled on exactly the terminal-count edge. It then checks that the following period already uses the new ratio. A second strobe is placed one edge later, and the bench checks that this one waits a full extra period. A coincidence of the monitor toggle with the terminal count is covered as well, since both happen at the wrap of the first stage: the monitor half-periods must stay at 50 clocks while pulses are being produced.

// File: rtl/ref_divider.sv
`timescale 1ns/1ps
module ref_divider #(
  parameter int PRE_DIV = 100,
  parameter int DIV_W   = 5
)(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel_in,
  input  logic       load,
  output logic       cmp_pulse,
  output logic       mon_out
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam int HALF  = PRE_DIV / 2;

  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] ratio;
  logic [2:0]       pend_sel;
  logic [2:0]       active_sel;
  logic             pre_tc, mon_edge, div_last, tc;

  always_comb begin
    case (active_sel)
      3'd0: ratio = DIV_W'(16);
      3'd1: ratio = DIV_W'(8);
      3'd2: ratio = DIV_W'(4);
      3'd3: ratio = DIV_W'(2);
      3'd4: ratio = DIV_W'(20);
      3'd5: ratio = DIV_W'(10);
      3'd6: ratio = DIV_W'(5);
      3'd7: ratio = DIV_W'(1);
    endcase
  end

  assign pre_tc   = pre_cnt == PRE_W'(PRE_DIV - 1);
  assign mon_edge = pre_tc || (pre_cnt == PRE_W'(HALF - 1));
  assign div_last = div_cnt == (ratio - DIV_W'(1));
  assign tc       = pre_tc && div_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt    <= '0;
      div_cnt    <= '0;
      pend_sel   <= 3'd0;
      active_sel <= 3'd0;
      mon_out    <= 1'b0;
      cmp_pulse  <= 1'b0;
    end else begin
      pre_cnt   <= pre_tc ? '0 : pre_cnt + PRE_W'(1);
      cmp_pulse <= tc;
      if (mon_edge) mon_out <= ~mon_out;
      if (load) pend_sel <= sel_in;
      if (pre_tc) div_cnt <= div_last ? '0 : div_cnt + DIV_W'(1);
      if (tc) active_sel <= load ? sel_in : pend_sel;
    end
  end
endmodule

// File: rtl/ref_divider_chk.sv
`timescale 1ns/1ps
module ref_divider_chk #(
  parameter int PRE_DIV = 100,
  parameter int PRE_W   = 7
)(
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             cmp_pulse,
  input logic             mon_out,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [2:0]       pend_sel,
  input logic [2:0]       active_sel
);
  localparam int HALF = PRE_DIV / 2;

  AST_PULSE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |-> pre_cnt == '0); // R1
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmp_pulse |=> !cmp_pulse); // R2
  AST_MON_HALF_PERIOD: assert property (@(posedge clk) disable iff (rst)
    !$stable(mon_out) |-> ($past(pre_cnt) == PRE_W'(HALF - 1) || $past(pre_cnt) == PRE_W'(PRE_DIV - 1))); // R3
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(pend_sel)); // R4
  AST_CODE_AT_TC: assert property (@(posedge clk) disable iff (rst)
    !$stable(active_sel) |-> cmp_pulse); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!cmp_pulse && !mon_out && active_sel == 3'd0 && pend_sel == 3'd0)); // R7
endmodule

bind ref_divider ref_divider_chk #(.PRE_DIV(PRE_DIV), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .cmp_pulse(cmp_pulse), .mon_out(mon_out),
  .pre_cnt(pre_cnt), .pend_sel(pend_sel), .active_sel(active_sel)
);

// File: tb/sim_ref_divider.sv
`timescale 1ns/1ps
module sim_ref_divider;
  localparam int LIMIT = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel_in = 3'd0;
  logic       load = 1'b0;
  logic       cmp_pulse, mon_out;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;
  int         cur = 0;

  always #2 clk = ~clk;

  ref_divider u0 (.clk(clk), .rst(rst), .sel_in(sel_in), .load(load),
                  .cmp_pulse(cmp_pulse), .mon_out(mon_out));

  function automatic int exp_ratio(input int code);
    case (code)
      0: return 1600;  1: return 800;  2: return 400;  3: return 200;
      4: return 2000;  5: return 1000; 6: return 500;  default: return 100;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic gap(input int at1, input logic [2:0] c1, input int at2, input logic [2:0] c2,
                     output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      load = (n == at1) || (n == at2);
      if (n == at1) sel_in = c1;
      if (n == at2) sel_in = c2;
      if (cmp_pulse || n >= LIMIT) break;
    end
  endtask

  task automatic wait_mon(input logic lvl, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      load = (n == 1);
      if (mon_out == lvl || n >= LIMIT) break;
    end
  endtask

  task automatic apply_reset();
    load = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(cmp_pulse == 1'b0, "R7 reset cmp_pulse", int'(cmp_pulse), 0);
    check(mon_out == 1'b0, "R7 reset mon_out", int'(mon_out), 0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    int n;
    sel_in = 3'd5;
    apply_reset();
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 1600, "R7 first pulse after reset", n, 1600);
    cur = 0;
  endtask

  task automatic t_mon();
    int n;
    apply_reset();
    sel_in = 3'd7;
    wait_mon(1'b1, n);
    check(n == 50, "R7 first mon rise", n, 50);
    wait_mon(1'b0, n);
    check(n == 50, "R3 mon high time", n, 50);
    wait_mon(1'b1, n);
    check(n == 50, "R3 mon low time", n, 50);
    load = 1'b0;
    for (int k = 0; k < 20; k++) begin
      wait_mon(~mon_out, n);
      check(n == 50, "R3 mon half period with pulses", n, 50);
    end
    load = 1'b0;
  endtask

  task automatic t_codes();
    int n;
    apply_reset();
    gap(0, 3'd0, 0, 3'd0, n);
    cur = 0;
    for (int c = 0; c < 8; c++) begin
      gap(1, 3'(c), 0, 3'd0, n);
      check(n == exp_ratio(cur), "R5 period in progress keeps ratio", n, exp_ratio(cur));
      gap(0, 3'd0, 0, 3'd0, n);
      check(n == exp_ratio(c), "R1 ratio for code", n, exp_ratio(c));
      gap(0, 3'd0, 0, 3'd0, n);
      check(n == exp_ratio(c), "R1 ratio repeat", n, exp_ratio(c));
      cur = c;
    end
  endtask

  task automatic t_width();
    int n;
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 100, "R2 period before width check", n, 100);
    @(negedge clk);
    check(cmp_pulse == 1'b0, "R2 pulse one clock wide", int'(cmp_pulse), 0);
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 99, "R2 single pulse per period", n, 99);
  endtask

  task automatic t_ignore();
    int n;
    sel_in = 3'd2;
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 100, "R4 sel_in without load", n, 100);
    sel_in = 3'd0;
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 100, "R4 sel_in without load again", n, 100);
  endtask

  task automatic t_coincide();
    int n;
    gap(99, 3'd0, 0, 3'd0, n);
    check(n == 100, "R6 period ending at coincident load", n, 100);
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 1600, "R6 coincident load applies at once", n, 1600);
  endtask

  task automatic t_late();
    int n;
    gap(1600, 3'd7, 0, 3'd0, n);
    check(n == 1600, "R5 period before late load", n, 1600);
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 1600, "R5 late load waits a period", n, 1600);
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 100, "R5 late load then applied", n, 100);
  endtask

  task automatic t_last();
    int n;
    gap(10, 3'd1, 60, 3'd3, n);
    check(n == 100, "R8 period with two loads", n, 100);
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 200, "R8 last load wins", n, 200);
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 200, "R8 last load wins repeat", n, 200);
  endtask

  task automatic t_reset_mid();
    int n;
    repeat (37) @(negedge clk);
    load = 1'b0;
    apply_reset();
    gap(0, 3'd0, 0, 3'd0, n);
    check(n == 1600, "R7 mid-run reset restores code 000", n, 1600);
  endtask

  initial begin
    t_reset();
    t_mon();
    t_codes();
    t_width();
    t_ignore();
    t_coincide();
    t_late();
    t_last();
    t_reset_mid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule